// File: doc/BRIEF.md
# Atomic fetch-and-add register unit

This block keeps a bank of byte-addressed counters and applies read-modify-write operations to them one at a time, so every update is atomic with respect to all others. A request names an operation, a byte index, an access size (8, 16, 32 or 64 bits) and either a small signed increment packed into the request word or a full store operand. Synchronous load-adds return the value held before the update on a response channel. Asynchronous load-adds deliver that old value to a scratchpad write port instead. Stores either add to a counter or overwrite it.

A load-type request may ask to wait for an external tag switch to finish. While the tag-switch-pending input stays high, the operation is held and further requests are back-pressured. If the wait lasts for a parameter number of clock cycles, the operation is dropped and an error result is produced in its place. Misaligned or malformed requests are rejected without touching storage.

Top module: `fau_atomic_bank`

## Requirements
- R1: After reset every counter byte reads as zero, `req_ready` is 1, and `rsp_valid` and `scr_we` are 0.
- R2: Request op code 0 (load-add) selects byte index `req_word[10:0]` and size code `req_word[12:11]` (0=1, 1=2, 2=4, 3=8 bytes, little-endian within each 8-byte word). It adds the sign-extension of the 22-bit increment `req_word[35:14]`, wrapping modulo the access width, so only those 22 bits reach a 32- or 64-bit counter. In the cycle after acceptance it raises `rsp_valid` with `rsp_err`=0 and `rsp_data` holding the old value sign-extended to 64 bits.
- R3: Op code 1 (store) uses the low bytes of `req_data`. With `req_word[13]`=0 they are added to the counter, wrapping. With `req_word[13]`=1 they overwrite it. A valid store produces no response, and bytes outside the accessed size are unchanged.
- R4: Op code 2 (async load-add) updates the counter like R2. One cycle after acceptance it pulses `scr_we` with `scr_slot`=`req_word[63:56]` and `scr_data` holding the old value, and it raises no `rsp_valid`.
- R5: A request is rejected when the index is not a multiple of the access size, when the op code is 3, or when an async request has a length field `req_word[55:48]` other than 1. It leaves storage unchanged and produces an error result. An error result has its error flag set and data 64'h8000_0000_0000_0000. For async requests it goes to the scratchpad port, marked by bit 63. For all other requests it goes to the response port with `rsp_err`=1.
- R6: A load-add or async load-add with `req_word[13]`=1, accepted while `tag_pending` is 1, holds `req_ready` at 0 until `tag_pending` is seen low. It then executes with its original fields. Stores, and tag-wait requests accepted while `tag_pending` is 0, execute at once.
- R7: If `tag_pending` stays high at each of the `TIMEOUT_CYC` clock edges after acceptance, the stalled operation is dropped with an error result as in R5. The counter is not modified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 2 | Operation: 0 load-add, 1 store, 2 async load-add, 3 reserved |
| req_word | input | 64 | Packed request fields (index, size, flag, increment, length, slot) |
| req_data | input | 64 | Store operand |
| tag_pending | input | 1 | External tag switch not yet complete |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Response reports a rejected or timed-out request |
| rsp_data | output | 64 | Old counter value, sign-extended, or error word |
| scr_we | output | 1 | Scratchpad write strobe |
| scr_slot | output | SLOT_W (8) | Scratchpad word slot |
| scr_data | output | 64 | Old value or error word for the scratchpad |

## Verification
Increments are driven at all four sizes, including values that cross the signed limit of an 8-bit lane, a 16-bit store-add that wraps through zero, and a 32-bit increment with a bit set above the 22-bit field. The wrapped results and the ignored upper bit show whether the width masking is right. Neighbouring indices are read after narrow stores, and narrow loads are taken from a known 64-bit pattern, which tells little-endian lane placement apart from byte-swapped or over-wide writes. Misaligned, reserved-op and bad-length requests are each followed by reads of the counters they named, to show that storage stayed unchanged. Tag-wait requests are run with the pending input dropping early, never raised, and held past the timeout, alongside a store issued under pending. This separates stalling from immediate execution and from a timed-out drop.

// File: rtl/fau_pkg.sv
`timescale 1ns/1ps
package fau_pkg;

   localparam int WORD_W = 64;
   localparam int LANES  = WORD_W / 8;

   // request word field positions
   localparam int IDX_LSB  = 0;
   localparam int SIZE_LSB = 11;
   localparam int FLAG_BIT = 13;
   localparam int INC_LSB  = 14;
   localparam int LEN_LSB  = 48;
   localparam int SLOT_LSB = 56;

   localparam logic [WORD_W-1:0] ERR_WORD = {1'b1, {(WORD_W-1){1'b0}}};

   typedef enum logic [1:0] {
      OP_LOAD_ADD  = 2'd0,
      OP_STORE     = 2'd1,
      OP_ASYNC_ADD = 2'd2,
      OP_RSVD      = 2'd3
   } fau_op_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_STALL = 1'b1
   } fau_wait_e;

endpackage

// File: rtl/fau_req_decode.sv
`timescale 1ns/1ps
module fau_req_decode
   import fau_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int INC_W  = 22,
   parameter int SLOT_W = 8
) (
   input  logic [1:0]        op_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [WORD_W-1:0] data_i,
   output logic [ADDR_W-4:0] widx_o,
   output logic [2:0]        off_o,
   output logic [1:0]        size_o,
   output logic              flag_o,
   output logic [WORD_W-1:0] operand_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic [LANES-1:0]  byte_en_o,
   output logic              bad_o
);

   logic [ADDR_W-1:0] idx;
   logic [3:0]        nbytes;
   logic [2:0]        align_mask;
   logic              misaligned;
   logic [INC_W-1:0]  inc;
   logic [WORD_W-1:0] inc_ext;
   logic [7:0]        len;
   logic [3:0]        lane_end;
   logic              unused_fields;

   assign idx        = word_i[IDX_LSB +: ADDR_W];
   assign widx_o     = idx[ADDR_W-1:3];
   assign off_o      = idx[2:0];
   assign size_o     = word_i[SIZE_LSB +: 2];
   assign flag_o     = word_i[FLAG_BIT];
   assign nbytes     = 4'd1 << size_o;
   assign align_mask = nbytes[2:0] - 3'd1;
   assign misaligned = |(off_o & align_mask);

   assign inc        = word_i[INC_LSB +: INC_W];
   assign inc_ext    = {{(WORD_W-INC_W){inc[INC_W-1]}}, inc};
   assign operand_o  = (op_i == OP_STORE) ? data_i : inc_ext;

   assign len        = word_i[LEN_LSB +: 8];
   assign slot_o     = word_i[SLOT_LSB +: SLOT_W];

   assign bad_o = misaligned
                | (op_i == OP_RSVD)
                | ((op_i == OP_ASYNC_ADD) && (len != 8'd1));

   assign lane_end = {1'b0, off_o} + nbytes;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign byte_en_o[i] = ({1'b0, off_o} <= 4'(i)) && (4'(i) < lane_end);
   end

   assign unused_fields = ^word_i[LEN_LSB-1:INC_LSB+INC_W];

endmodule

// File: rtl/fau_lane_alu.sv
`timescale 1ns/1ps
module fau_lane_alu
   import fau_pkg::*;
(
   input  logic [WORD_W-1:0] old_word_i,
   input  logic [2:0]        off_i,
   input  logic [1:0]        size_i,
   input  logic [WORD_W-1:0] operand_i,
   input  logic              overwrite_i,
   input  logic [LANES-1:0]  byte_en_i,
   output logic [WORD_W-1:0] new_word_o,
   output logic [WORD_W-1:0] old_val_o
);

   logic [5:0]        shamt;
   logic [WORD_W-1:0] lane;
   logic [WORD_W-1:0] result;
   logic [WORD_W-1:0] placed;

   assign shamt  = {off_i, 3'b000};
   assign lane   = old_word_i >> shamt;
   assign result = overwrite_i ? operand_i : (lane + operand_i);
   assign placed = result << shamt;

   for (genvar i = 0; i < LANES; i++) begin : g_merge
      assign new_word_o[8*i +: 8] = byte_en_i[i] ? placed[8*i +: 8]
                                                 : old_word_i[8*i +: 8];
   end

   always_comb begin
      case (size_i)
         2'd0:    old_val_o = {{(WORD_W-8){lane[7]}},   lane[7:0]};
         2'd1:    old_val_o = {{(WORD_W-16){lane[15]}}, lane[15:0]};
         2'd2:    old_val_o = {{(WORD_W-32){lane[31]}}, lane[31:0]};
         default: old_val_o = lane;
      endcase
   end

endmodule

// File: rtl/fau_wait_ctrl.sv
`timescale 1ns/1ps
module fau_wait_ctrl
   import fau_pkg::*;
#(
   parameter int TIMEOUT_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid_i,
   input  logic wait_req_i,
   input  logic tag_pending_i,
   output logic ready_o,
   output logic waiting_o,
   output logic go_o,
   output logic tmo_o
);

   localparam int CNT_W = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

   fau_wait_e        state;
   logic [CNT_W-1:0] cnt;
   logic             accept;
   logic             at_limit;

   assign waiting_o = (state == ST_STALL);
   assign ready_o   = !waiting_o;
   assign accept    = req_valid_i && ready_o;
   assign at_limit  = (cnt == LAST);

   assign go_o  = waiting_o ? !tag_pending_i : (accept && !wait_req_i);
   assign tmo_o = waiting_o && tag_pending_i && at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else if (state == ST_IDLE) begin
         if (accept && wait_req_i) begin
            state <= ST_STALL;
            cnt   <= '0;
         end
      end else if (!tag_pending_i || at_limit) begin
         state <= ST_IDLE;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/fau_atomic_bank.sv
`timescale 1ns/1ps
module fau_atomic_bank
   import fau_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int INC_W       = 22,
   parameter int SLOT_W      = 8,
   parameter int TIMEOUT_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [63:0]       req_word,
   input  logic [63:0]       req_data,
   input  logic              tag_pending,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [63:0]       rsp_data,
   output logic              scr_we,
   output logic [SLOT_W-1:0] scr_slot,
   output logic [63:0]       scr_data
);

   localparam int WIDX_W    = ADDR_W - 3;
   localparam int NUM_WORDS = 1 << WIDX_W;

   if (ADDR_W < 4 || ADDR_W > SIZE_LSB) begin : g_chk_addr
      $error("fau_atomic_bank: ADDR_W must lie in 4..11");
   end
   if (INC_W < 2 || INC_W > FLAG_BIT + 9) begin : g_chk_inc
      $error("fau_atomic_bank: INC_W must lie in 2..22");
   end
   if (SLOT_W < 1 || SLOT_W > WORD_W - SLOT_LSB) begin : g_chk_slot
      $error("fau_atomic_bank: SLOT_W must lie in 1..8");
   end
   if (TIMEOUT_CYC < 1) begin : g_chk_tmo
      $error("fau_atomic_bank: TIMEOUT_CYC must be at least 1");
   end

   // held request while stalled on a tag switch
   logic [1:0]        hold_op;
   logic [WORD_W-1:0] hold_word;
   logic [WORD_W-1:0] hold_data;

   logic              waiting;
   logic              go;
   logic              tmo;
   logic              wait_req;

   logic [1:0]        cur_op;
   logic [WORD_W-1:0] cur_word;
   logic [WORD_W-1:0] cur_data;

   logic [WIDX_W-1:0] widx;
   logic [2:0]        off;
   logic [1:0]        size;
   logic              flag;
   logic [WORD_W-1:0] operand;
   logic [SLOT_W-1:0] slot;
   logic [LANES-1:0]  byte_en;
   logic              bad;

   logic [WORD_W-1:0] mem [NUM_WORDS];
   logic [WORD_W-1:0] old_word;
   logic [WORD_W-1:0] new_word;
   logic [WORD_W-1:0] old_val;
   logic              overwrite;
   logic              is_load_type;
   logic              commit;
   logic              finish;
   logic              res_err;
   logic [WORD_W-1:0] res_data;

   assign cur_op   = waiting ? hold_op   : req_op;
   assign cur_word = waiting ? hold_word : req_word;
   assign cur_data = waiting ? hold_data : req_data;

   fau_req_decode #(
      .ADDR_W (ADDR_W),
      .INC_W  (INC_W),
      .SLOT_W (SLOT_W)
   ) u_dec (
      .op_i      (cur_op),
      .word_i    (cur_word),
      .data_i    (cur_data),
      .widx_o    (widx),
      .off_o     (off),
      .size_o    (size),
      .flag_o    (flag),
      .operand_o (operand),
      .slot_o    (slot),
      .byte_en_o (byte_en),
      .bad_o     (bad)
   );

   assign is_load_type = (cur_op == OP_LOAD_ADD) || (cur_op == OP_ASYNC_ADD);
   assign wait_req     = flag && is_load_type && !bad && tag_pending;

   fau_wait_ctrl #(
      .TIMEOUT_CYC (TIMEOUT_CYC)
   ) u_wait (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid_i   (req_valid),
      .wait_req_i    (wait_req),
      .tag_pending_i (tag_pending),
      .ready_o       (req_ready),
      .waiting_o     (waiting),
      .go_o          (go),
      .tmo_o         (tmo)
   );

   assign old_word  = mem[widx];
   assign overwrite = (cur_op == OP_STORE) && flag;

   fau_lane_alu u_alu (
      .old_word_i  (old_word),
      .off_i       (off),
      .size_i      (size),
      .operand_i   (operand),
      .overwrite_i (overwrite),
      .byte_en_i   (byte_en),
      .new_word_o  (new_word),
      .old_val_o   (old_val)
   );

   assign commit   = go && !bad;
   assign finish   = go || tmo;
   assign res_err  = tmo || bad;
   assign res_data = res_err ? ERR_WORD : old_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_op   <= '0;
         hold_word <= '0;
         hold_data <= '0;
      end else if (req_valid && req_ready) begin
         hold_op   <= req_op;
         hold_word <= req_word;
         hold_data <= req_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < NUM_WORDS; w++) begin
            mem[w] <= '0;
         end
      end else if (commit) begin
         mem[widx] <= new_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_data  <= '0;
         scr_we    <= 1'b0;
         scr_slot  <= '0;
         scr_data  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         scr_we    <= 1'b0;
         if (finish) begin
            if (cur_op == OP_ASYNC_ADD) begin
               scr_we   <= 1'b1;
               scr_slot <= slot;
               scr_data <= res_data;
            end else if (cur_op == OP_LOAD_ADD || res_err) begin
               rsp_valid <= 1'b1;
               rsp_err   <= res_err;
               rsp_data  <= res_data;
            end
         end
      end
   end

endmodule

// File: rtl/fau_atomic_bank_chk.sv
`timescale 1ns/1ps
module fau_atomic_bank_chk #(
   parameter int SLOT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        req_op,
   input logic [63:0]       req_word,
   input logic              tag_pending,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [63:0]       rsp_data,
   input logic              scr_we,
   input logic [SLOT_W-1:0] scr_slot
);

   logic acc;
   logic stalls;
   assign acc    = req_valid && req_ready;
   assign stalls = req_word[13] && tag_pending;

   // R2: an unstalled load-add answers in the next cycle
   assert_load_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_op == 2'd0 && !stalls) |=> rsp_valid);

   // R3: a byte-sized store is silent on both result ports
   assert_store_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_op == 2'd1 && req_word[12:11] == 2'd0) |=> (!rsp_valid && !scr_we));

   // R4: an unstalled async request writes the slot it named
   assert_async_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_op == 2'd2 && !stalls) |=> (scr_we && !rsp_valid &&
                                              scr_slot == $past(req_word[56 +: SLOT_W])));

   // R5: an error response always carries the top flag bit
   assert_err_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> rsp_data[63]);

   // R6: an aligned tag-wait load under pending back-pressures the channel
   assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_op == 2'd0 && req_word[12:11] == 2'd0 && stalls) |=> !req_ready);

   // R6: a stalled request produces no result while pending stays high
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && tag_pending && $stable(req_ready)) |-> (!rsp_valid && !scr_we));

endmodule

bind fau_atomic_bank fau_atomic_bank_chk #(.SLOT_W(SLOT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_op      (req_op),
   .req_word    (req_word),
   .tag_pending (tag_pending),
   .rsp_valid   (rsp_valid),
   .rsp_err     (rsp_err),
   .rsp_data    (rsp_data),
   .scr_we      (scr_we),
   .scr_slot    (scr_slot)
);

// File: tb/sim_fau_atomic_bank.sv
`timescale 1ns/1ps
module sim_fau_atomic_bank;

   localparam int TMO = 8;
   localparam logic [63:0] ERRW = 64'h8000_0000_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = '0;
   logic [63:0] req_word = '0;
   logic [63:0] req_data = '0;
   logic        tag_pending = 1'b0;
   logic        rsp_valid;
   logic        rsp_err;
   logic [63:0] rsp_data;
   logic        scr_we;
   logic [7:0]  scr_slot;
   logic [63:0] scr_data;

   always #10 clk = ~clk;

   fau_atomic_bank #(.TIMEOUT_CYC(TMO)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_word(req_word), .req_data(req_data), .tag_pending(tag_pending),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
      .scr_we(scr_we), .scr_slot(scr_slot), .scr_data(scr_data)
   );

   int n_checks = 0;
   int n_errors = 0;
   logic [7:0]  bmem [2048];
   logic [64:0] rsp_q [$];
   string       rsp_tag_q [$];
   logic [71:0] scr_q [$];
   string       scr_tag_q [$];

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   function automatic logic [63:0] m_rd(input int idx, input int sz);
      logic [63:0] v = '0;
      for (int b = 0; b < (1 << sz); b++) v[8*b +: 8] = bmem[idx + b];
      case (sz)
         0: v = {{56{v[7]}},  v[7:0]};
         1: v = {{48{v[15]}}, v[15:0]};
         2: v = {{32{v[31]}}, v[31:0]};
         default: ;
      endcase
      return v;
   endfunction

   task automatic m_wr(input int idx, input int sz, input logic [63:0] v);
      for (int b = 0; b < (1 << sz); b++) bmem[idx + b] = v[8*b +: 8];
   endtask

   task automatic send(input logic [1:0] op, input logic [63:0] w, input logic [63:0] d);
      @(negedge clk);
      req_op = op; req_word = w; req_data = d; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   // builds the request, updates the model and queues the expected result
   task automatic op_req(input logic [1:0] op, input int idx, input int sz, input bit flag,
                         input logic [63:0] val, input int slot, input int len,
                         input string tag, input bit tmo);
      logic [63:0] w = '0;
      logic [63:0] operand;
      logic [63:0] old;
      logic [63:0] res;
      bit          bad;
      bit          err;
      w[10:0]  = idx[10:0];
      w[12:11] = sz[1:0];
      w[13]    = flag;
      if (op != 2'd1) w[35:14] = val[21:0];
      w[55:48] = len[7:0];
      w[63:56] = slot[7:0];
      bad = ((idx % (1 << sz)) != 0) || (op == 2'd3) || (op == 2'd2 && len != 1);
      err = bad || tmo;
      if (!err) begin
         old     = m_rd(idx, sz);
         operand = (op == 2'd1) ? val : {{42{w[35]}}, w[35:14]};
         m_wr(idx, sz, (op == 2'd1 && flag) ? operand : old + operand);
         res = old;
      end else begin
         res = ERRW;
      end
      if (op == 2'd2) begin
         scr_q.push_back({w[63:56], res});
         scr_tag_q.push_back(tag);
      end else if (op == 2'd0 || err) begin
         rsp_q.push_back({err, res});
         rsp_tag_q.push_back(tag);
      end
      send(op, w, (op == 2'd1) ? val : 64'h0);
   endtask

   task automatic tw_req(input logic [1:0] op, input int idx, input int sz, input logic [63:0] val,
                         input int slot, input int hold, input string tag);
      tag_pending = 1'b1;
      op_req(op, idx, sz, 1'b1, val, slot, 1, tag, hold > TMO);
      for (int j = 1; j <= hold; j++) begin
         @(negedge clk);
         if (j <= 3) chk(req_ready == 1'b0, {tag, " ready held low"}, {63'b0, req_ready}, 64'h0);
      end
      tag_pending = 1'b0;
   endtask

   // monitor: compare results as they come out
   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_valid) begin
            if (rsp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected response", rsp_data, 64'h0);
            end else begin
               logic [64:0] e;
               string t;
               e = rsp_q.pop_front();
               t = rsp_tag_q.pop_front();
               chk(rsp_data == e[63:0], t, rsp_data, e[63:0]);
               chk(rsp_err == e[64], {t, " err flag"}, {63'b0, rsp_err}, {63'b0, e[64]});
            end
         end
         if (scr_we) begin
            if (scr_q.size() == 0) begin
               chk(1'b0, "R4 unexpected scratch write", scr_data, 64'h0);
            end else begin
               logic [71:0] e;
               string t;
               e = scr_q.pop_front();
               t = scr_tag_q.pop_front();
               chk(scr_data == e[63:0], t, scr_data, e[63:0]);
               chk(scr_slot == e[71:64], {t, " slot"}, {56'b0, scr_slot}, {56'b0, e[71:64]});
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog expired", 64'h0, 64'h1);
      finish_run();
   end

   initial begin
      for (int i = 0; i < 2048; i++) bmem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 ready after reset", {63'b0, req_ready}, 64'h1);
      chk(rsp_valid == 1'b0, "R1 no response after reset", {63'b0, rsp_valid}, 64'h0);
      chk(scr_we == 1'b0, "R1 no scratch write after reset", {63'b0, scr_we}, 64'h0);
      op_req(0, 0, 3, 0, 0, 0, 1, "R1 zero counter", 0);
      op_req(0, 2040, 3, 0, 0, 0, 1, "R1 zero top counter", 0);

      // R2 64-bit load-add sequence
      op_req(0, 8, 3, 0, 5, 0, 1, "R2 add +5", 0);
      op_req(0, 8, 3, 0, -64'sd3, 0, 1, "R2 add -3", 0);
      op_req(0, 8, 3, 0, 0, 0, 1, "R2 read back", 0);

      // R3 8-bit overwrite then R2 wrap across signed limit
      op_req(1, 3, 0, 1, 64'h7F, 0, 1, "R3 byte overwrite", 0);
      op_req(0, 3, 0, 0, 1, 0, 1, "R2 byte old 7F", 0);
      op_req(0, 3, 0, 0, 0, 0, 1, "R2 byte sign extend", 0);
      op_req(0, 2, 0, 0, 0, 0, 1, "R3 lower neighbour untouched", 0);
      op_req(0, 4, 0, 0, 0, 0, 1, "R3 upper neighbour untouched", 0);

      // R3 16-bit store-add wrap
      op_req(1, 16, 1, 1, 64'hFFFF, 0, 1, "R3 half overwrite", 0);
      op_req(1, 16, 1, 0, 64'h2, 0, 1, "R3 half store-add", 0);
      op_req(0, 16, 1, 0, 0, 0, 1, "R3 half wrapped", 0);
      op_req(0, 18, 1, 0, 0, 0, 1, "R3 half neighbour", 0);

      // R2 32-bit, increment limited to 22 bits
      op_req(0, 32, 2, 0, -64'sd1, 0, 1, "R2 word add -1", 0);
      op_req(0, 32, 2, 0, 64'h40_0001, 0, 1, "R2 word old -1", 0);
      op_req(0, 32, 2, 0, 0, 0, 1, "R2 word only 22 bits", 0);

      // R2 little-endian lanes
      op_req(1, 24, 3, 1, 64'h0807_0605_0403_0201, 0, 1, "R3 dword overwrite", 0);
      op_req(0, 27, 0, 0, 0, 0, 1, "R2 lane byte 3", 0);
      op_req(0, 26, 1, 0, 0, 0, 1, "R2 lane half at 26", 0);
      op_req(0, 28, 2, 0, 0, 0, 1, "R2 lane word at 28", 0);

      // R4 async load-add
      op_req(2, 24, 3, 0, 16, 5, 1, "R4 async dword", 0);
      op_req(0, 24, 3, 0, 0, 0, 1, "R4 async updated counter", 0);
      op_req(2, 40, 1, 0, -64'sd2, 200, 1, "R4 async half", 0);
      op_req(0, 40, 1, 0, 0, 0, 1, "R4 async half result", 0);

      // R5 rejections, then counters unchanged
      op_req(0, 34, 2, 0, 1, 0, 1, "R5 misaligned load", 0);
      op_req(1, 17, 1, 1, 64'h55, 0, 1, "R5 misaligned store", 0);
      op_req(2, 44, 3, 0, 1, 3, 1, "R5 misaligned async", 0);
      op_req(2, 40, 1, 0, 1, 9, 2, "R5 async bad length", 0);
      op_req(3, 0, 0, 0, 1, 0, 1, "R5 reserved op", 0);
      op_req(0, 32, 2, 0, 0, 0, 1, "R5 word unchanged", 0);
      op_req(0, 16, 1, 0, 0, 0, 1, "R5 half unchanged", 0);
      op_req(0, 40, 1, 0, 0, 0, 1, "R5 async target unchanged", 0);
      op_req(0, 40, 3, 0, 0, 0, 1, "R5 dword at 40 unchanged", 0);

      // R6 tag-wait with release, immediate cases
      tw_req(0, 8, 3, 10, 0, 3, "R6 tag-wait load");
      op_req(0, 8, 3, 0, 0, 0, 1, "R6 after tag-wait load", 0);
      tw_req(2, 24, 3, 1, 7, 2, "R6 tag-wait async");
      op_req(0, 8, 3, 1, 4, 0, 1, "R6 tag-wait without pending", 0);
      tag_pending = 1'b1;
      op_req(1, 8, 3, 0, 64'h100, 0, 1, "R6 store under pending", 0);
      @(negedge clk);
      chk(req_ready == 1'b1, "R6 store not stalled", {63'b0, req_ready}, 64'h1);
      tag_pending = 1'b0;
      op_req(0, 8, 3, 0, 0, 0, 1, "R6 store applied", 0);

      // R7 timeout leaves counters alone
      tw_req(0, 8, 3, 1000, 0, TMO + 3, "R7 load timeout");
      op_req(0, 8, 3, 0, 0, 0, 1, "R7 counter unchanged", 0);
      tw_req(2, 24, 3, 1000, 11, TMO + 2, "R7 async timeout");
      op_req(0, 24, 3, 0, 0, 0, 1, "R7 async counter unchanged", 0);

      repeat (5) @(negedge clk);
      chk(rsp_q.size() == 0, "R2 all responses seen", rsp_q.size(), 0);
      chk(scr_q.size() == 0, "R4 all scratch writes seen", scr_q.size(), 0);
      finish_run();
   end

endmodule